// File: doc/BRIEF.md
# Slot Clock Timer with Comparators

This block keeps the radio time base. A 1 µs tick enable drives it. Time has two parts. The fine part is a 10-bit microsecond down-counter that runs through one 625 µs slot. The coarse part is a 28-bit up-counter that counts half-slots. Software and the receive and transmit datapaths never read the running counters directly. Each of them strobes its own capture register, and that register holds a coherent copy of the whole value until the next strobe.

Four compare channels hold target times in the same composite format. When an armed channel's target equals the current time, the channel raises a sticky interrupt flag and disarms itself. The channel chosen by a parameter also sends a one-cycle trigger to the scheduled-transmit logic. The comparison is an equality test, so a target keeps working when the coarse counter wraps.

Top module: `slot_clock_timer`

## Requirements
- R1: After reset, the fine count is 624 and the coarse count is 0. All three capture outputs read 0, and no channel is armed or flagged. `tx_trig` is low.
- R2: The time changes only in cycles where `tick_1us` is high. Each tick lowers the fine count by one unless the fine count is 0.
- R3: On a tick with the fine count at 0, the fine count reloads 624 and the coarse count increments. The coarse count also increments on the tick that moves the fine count from 313 to 312. This gives two coarse steps per 625 ticks.
- R4: `latch_req` copies the composite time into `latch_val`, with the coarse count in bits 37:10 and the fine count in bits 9:0. The value copied is the time before that edge's update. `latch_val` holds until the next request.
- R5: `rx_sof` captures the time into `rx_ts`, and `tx_sof` captures it into `tx_ts`. A strobe on one leaves the other register unchanged.
- R6: `cmp_we[i]` loads `cmp_wdata` as the target of channel i and arms the channel. `cmp_disarm[i]` disarms the channel. If both arrive in the same cycle, the write wins.
- R7: When armed channel i has a target equal to the current time, the next edge sets `cmp_irq[i]` and clears `cmp_armed[i]`. A target the clock has already passed never fires.
- R8: `cmp_irq[i]` stays set until a cycle with `irq_clr[i]` high. If a new match and the clear arrive in the same cycle, the flag stays set.
- R9: A match on channel `TX_CMP` (default 0) pulses `tx_trig` for one cycle, in the same cycle its flag sets. Matches on the other channels leave `tx_trig` low.
- R10: The coarse count wraps modulo 2^HS_W, back to 0, and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle enable, once per microsecond |
| latch_req | input | 1 | Software read latch strobe |
| rx_sof | input | 1 | Received MAC header start strobe |
| tx_sof | input | 1 | Transmitted MAC header start strobe |
| cmp_we | input | 4 | Per-channel write target and arm |
| cmp_wdata | input | 38 | Target time, composite format |
| cmp_disarm | input | 4 | Per-channel disarm |
| irq_clr | input | 4 | Per-channel write-1 flag clear |
| latch_val | output | 38 | Latched time |
| rx_ts | output | 38 | Receive timestamp |
| tx_ts | output | 38 | Transmit timestamp |
| cmp_irq | output | 4 | Sticky match flags |
| cmp_armed | output | 4 | Channel armed state |
| tx_trig | output | 1 | Scheduled-transmit trigger pulse |

## Verification
The properties assume that `tick_1us` is never high in two adjacent cycles, so the counter can settle between steps. They also assume that reset is applied before any strobe. The stimulus raises the tick for one cycle at a time with idle cycles between ticks. All strobes, writes and clears arrive as single-cycle pulses away from the active edge. Compare targets are always written as pairs the counter can actually reach, with the fine part between 0 and 624.

// File: rtl/slot_timer_pkg.sv
// Shared constants and types for the slot clock timer.
package slot_timer_pkg;
    localparam int DEF_US_W    = 10;
    localparam int DEF_HS_W    = 28;
    localparam int DEF_SLOT_US = 625;
    localparam int DEF_NUM_CMP = 4;

    // Capture register sources, in instance order.
    typedef enum logic [1:0] {
        CAP_LATCH = 2'd0,
        CAP_RX    = 2'd1,
        CAP_TX    = 2'd2
    } cap_src_e;
    localparam int NUM_CAP = 3;
endpackage

// File: rtl/slot_timebase.sv
// Composite time base: the microsecond down-counter spans one slot, and
// the half-slot up-counter steps twice per slot.
// Assumes tick is a single-cycle enable.
module slot_timebase #(
    parameter int US_W    = 10,
    parameter int HS_W    = 28,
    parameter int SLOT_US = 625
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [US_W-1:0] us_o,
    output logic [HS_W-1:0] hs_o
);
    localparam logic [US_W-1:0] RELOAD  = US_W'(SLOT_US - 1);
    localparam logic [US_W-1:0] MID_PRE = US_W'(SLOT_US / 2 + 1);

    // Step both counters on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            us_o <= RELOAD;
            hs_o <= '0;
        end else if (tick) begin
            if (us_o == '0) begin
                us_o <= RELOAD;
                hs_o <= hs_o + 1'b1;
            end else begin
                us_o <= us_o - 1'b1;
                if (us_o == MID_PRE)
                    hs_o <= hs_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/slot_capture.sv
// Capture register: on a strobe, holds a copy of the composite time.
// Assumes the input changes only at clock edges.
module slot_capture #(
    parameter int W = 38
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (strobe)
            q <= din;
    end
endmodule

// File: rtl/slot_cmp_chan.sv
// One-shot compare channel. The match is an equality test against the
// current time. A match disarms the channel, sets a sticky flag and, on
// the transmit channel, pulses a trigger. Assumes the target is written
// in the composite format.
module slot_cmp_chan #(
    parameter int W     = 38,
    parameter bit IS_TX = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] now,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         disarm,
    input  logic         clr,
    output logic         armed,
    output logic         flag,
    output logic         trig
);
    logic [W-1:0] target;
    logic         hit;

    // A write in the same cycle suppresses the match.
    always_comb hit = armed && (target == now) && !we;

    // Target storage and arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
            armed  <= 1'b0;
        end else if (we) begin
            target <= wdata;
            armed  <= 1'b1;
        end else if (disarm || hit) begin
            armed  <= 1'b0;
        end
    end

    // Sticky flag; a match wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    generate
        if (IS_TX) begin : g_trig
            // Registered trigger pulse, aligned with the flag.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    trig <= 1'b0;
                else
                    trig <= hit;
            end
        end else begin : g_notrig
            assign trig = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/slot_clock_timer.sv
// Top: a time base, three capture registers and NUM_CMP compare channels.
// Assumes all strobes are synchronous single-cycle pulses.
module slot_clock_timer
    import slot_timer_pkg::*;
#(
    parameter int US_W    = DEF_US_W,
    parameter int HS_W    = DEF_HS_W,
    parameter int SLOT_US = DEF_SLOT_US,
    parameter int NUM_CMP = DEF_NUM_CMP,
    parameter int TX_CMP  = 0,
    localparam int TW     = US_W + HS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_1us,
    input  logic               latch_req,
    input  logic               rx_sof,
    input  logic               tx_sof,
    input  logic [NUM_CMP-1:0] cmp_we,
    input  logic [TW-1:0]      cmp_wdata,
    input  logic [NUM_CMP-1:0] cmp_disarm,
    input  logic [NUM_CMP-1:0] irq_clr,
    output logic [TW-1:0]      latch_val,
    output logic [TW-1:0]      rx_ts,
    output logic [TW-1:0]      tx_ts,
    output logic [NUM_CMP-1:0] cmp_irq,
    output logic [NUM_CMP-1:0] cmp_armed,
    output logic               tx_trig
);
    logic [US_W-1:0]    cur_us;
    logic [HS_W-1:0]    cur_hs;
    logic [TW-1:0]      now;
    logic [NUM_CAP-1:0] cap_stb;
    logic [TW-1:0]      cap_q [NUM_CAP];
    logic [NUM_CMP-1:0] trig_v;

    slot_timebase #(.US_W(US_W), .HS_W(HS_W), .SLOT_US(SLOT_US)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick_1us), .us_o(cur_us), .hs_o(cur_hs)
    );

    // Composite view: coarse count above the fine count.
    always_comb now = {cur_hs, cur_us};

    // Map the strobes to the capture instances.
    always_comb begin
        cap_stb            = '0;
        cap_stb[CAP_LATCH] = latch_req;
        cap_stb[CAP_RX]    = rx_sof;
        cap_stb[CAP_TX]    = tx_sof;
    end

    generate
        for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
            slot_capture #(.W(TW)) u_cap (
                .clk(clk), .rst_n(rst_n), .strobe(cap_stb[c]), .din(now), .q(cap_q[c])
            );
        end
        for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
            slot_cmp_chan #(.W(TW), .IS_TX(i == TX_CMP)) u_ch (
                .clk(clk), .rst_n(rst_n), .now(now),
                .we(cmp_we[i]), .wdata(cmp_wdata), .disarm(cmp_disarm[i]),
                .clr(irq_clr[i]), .armed(cmp_armed[i]), .flag(cmp_irq[i]),
                .trig(trig_v[i])
            );
        end
    endgenerate

    assign latch_val = cap_q[CAP_LATCH];
    assign rx_ts     = cap_q[CAP_RX];
    assign tx_ts     = cap_q[CAP_TX];
    assign tx_trig   = trig_v[TX_CMP];
endmodule

// File: rtl/slot_clock_timer_chk.sv
// Assertion checker, bound to every slot_clock_timer instance.
// Assumes ticks are never in adjacent cycles.
module slot_clock_timer_chk #(
    parameter int US_W    = 10,
    parameter int HS_W    = 28,
    parameter int SLOT_US = 625,
    parameter int NUM_CMP = 4,
    parameter int TX_CMP  = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_1us,
    input logic                 latch_req,
    input logic [US_W-1:0]      cur_us,
    input logic [HS_W-1:0]      cur_hs,
    input logic [US_W+HS_W-1:0] latch_val,
    input logic [NUM_CMP-1:0]   cmp_irq,
    input logic [NUM_CMP-1:0]   cmp_armed,
    input logic                 tx_trig
);
    localparam logic [US_W-1:0] RELOAD = US_W'(SLOT_US - 1);

    p_us_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cur_us <= RELOAD);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1us |=> ($stable(cur_us) && $stable(cur_hs)));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1us && cur_us != '0) |=> (cur_us == US_W'($past(cur_us) - 1'b1)));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1us && cur_us == '0) |=>
        (cur_us == RELOAD && cur_hs == HS_W'($past(cur_hs) + 1'b1)));

    p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |=> (latch_val == $past({cur_hs, cur_us})));

    p_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_trig |-> (cmp_irq[TX_CMP] && !cmp_armed[TX_CMP]));

    generate
        for (genvar i = 0; i < NUM_CMP; i++) begin : g_chan
            p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cmp_irq[i]) |-> !cmp_armed[i]);
        end
    endgenerate
endmodule

bind slot_clock_timer slot_clock_timer_chk #(
    .US_W(US_W), .HS_W(HS_W), .SLOT_US(SLOT_US), .NUM_CMP(NUM_CMP), .TX_CMP(TX_CMP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .latch_req(latch_req),
    .cur_us(cur_us), .cur_hs(cur_hs), .latch_val(latch_val),
    .cmp_irq(cmp_irq), .cmp_armed(cmp_armed), .tx_trig(tx_trig)
);

// File: tb/tb_slot_clock_timer.sv
// Scoreboard bench. Driver tasks queue the expected values and a monitor
// process compares them at the falling edge.
module tb_slot_clock_timer;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0, tick_1us = 1'b0, latch_req = 1'b0;
    logic        rx_sof = 1'b0, tx_sof = 1'b0;
    logic [3:0]  cmp_we = '0, cmp_disarm = '0, irq_clr = '0;
    logic [37:0] cmp_wdata = '0;
    logic [37:0] latch_val, rx_ts, tx_ts;
    logic [3:0]  cmp_irq, cmp_armed;
    logic        tx_trig;
    logic [12:0] s_latch, s_rx, s_tx;
    logic [3:0]  s_irq, s_armed;
    logic        s_trig;

    slot_clock_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .latch_req(latch_req),
        .rx_sof(rx_sof), .tx_sof(tx_sof), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .cmp_disarm(cmp_disarm), .irq_clr(irq_clr), .latch_val(latch_val),
        .rx_ts(rx_ts), .tx_ts(tx_ts), .cmp_irq(cmp_irq), .cmp_armed(cmp_armed),
        .tx_trig(tx_trig)
    );

    // Narrow coarse counter, used to reach the wrap.
    slot_clock_timer #(.HS_W(3)) dut_small (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .latch_req(latch_req),
        .rx_sof(rx_sof), .tx_sof(tx_sof), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata[12:0]),
        .cmp_disarm(cmp_disarm), .irq_clr(irq_clr), .latch_val(s_latch),
        .rx_ts(s_rx), .tx_ts(s_tx), .cmp_irq(s_irq), .cmp_armed(s_armed),
        .tx_trig(s_trig)
    );

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    int errors = 0, checks = 0, trig_cnt = 0;
    int exp_us = 624, exp_hs = 0;
    bit done = 0;

    function automatic logic [63:0] pack(int hs, int us);
        return (64'(hs) & 64'hFFF_FFFF) << 10 | 64'(us);
    endfunction

    // Time n ticks ahead, derived from the counting rules.
    function automatic logic [63:0] future(int n);
        int u = exp_us, h = exp_hs;
        for (int k = 0; k < n; k++) begin
            if (u == 0) begin u = 624; h++; end
            else begin if (u == 313) h++; u--; end
        end
        return pack(h, u);
    endfunction

    // Monitor: pop expected items and compare them with the outputs.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sbq.pop_front();
            case (it.kind)
                0: act = 64'(latch_val);
                1: act = 64'(rx_ts);
                2: act = 64'(tx_ts);
                3: act = 64'(cmp_irq);
                4: act = 64'(cmp_armed);
                5: act = 64'(trig_cnt);
                default: act = 64'(s_latch);
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    always @(negedge clk) if (tx_trig) trig_cnt++;

    task automatic expect_val(int kind, logic [63:0] e, string tag);
        sbq.push_back('{kind, e, tag});
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic tick_n(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick_1us = 1'b1;
            @(negedge clk) tick_1us = 1'b0;
            if (exp_us == 0) begin exp_us = 624; exp_hs++; end
            else begin if (exp_us == 313) exp_hs++; exp_us--; end
        end
    endtask

    task automatic do_latch();
        @(negedge clk) latch_req = 1'b1;
        @(negedge clk) latch_req = 1'b0;
    endtask

    task automatic arm(int ch, logic [63:0] v);
        @(negedge clk) begin cmp_we = 4'(1 << ch); cmp_wdata = v[37:0]; end
        @(negedge clk) cmp_we = '0;
    endtask

    task automatic disarm(int ch);
        @(negedge clk) cmp_disarm = 4'(1 << ch);
        @(negedge clk) cmp_disarm = '0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] old_t, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_val(0, 0, "R1 latch reset");
        expect_val(1, 0, "R1 rx reset");
        expect_val(2, 0, "R1 tx reset");
        expect_val(3, 0, "R1 irq reset");
        expect_val(4, 0, "R1 armed reset");
        do_latch();
        expect_val(0, pack(0, 624), "R1 start time");
        repeat (5) @(negedge clk);
        do_latch();
        expect_val(0, pack(0, 624), "R2 no tick no change");
        tick_n(1); do_latch();
        expect_val(0, pack(0, 623), "R2 one tick");
        old_t = pack(exp_hs, exp_us);
        tick_n(310); do_latch();
        expect_val(0, pack(0, 313), "R3 before mid step");
        tick_n(1); do_latch();
        expect_val(0, pack(1, 312), "R3 mid step");
        tick_n(312); do_latch();
        expect_val(0, pack(1, 0), "R3 end of slot");
        tick_n(1); do_latch();
        expect_val(0, pack(2, 624), "R3 reload");
        // Timestamps
        @(negedge clk) rx_sof = 1'b1;
        @(negedge clk) rx_sof = 1'b0;
        expect_val(1, pack(exp_hs, exp_us), "R5 rx capture");
        expect_val(2, 0, "R5 tx untouched");
        tick_n(7);
        @(negedge clk) tx_sof = 1'b1;
        @(negedge clk) tx_sof = 1'b0;
        expect_val(2, pack(exp_hs, exp_us), "R5 tx capture");
        expect_val(1, pack(2, 624), "R5 rx untouched");
        // Non-transmit channel match
        arm(1, future(3));
        expect_val(4, 4'b0010, "R6 arm ch1");
        tick_n(3); @(negedge clk);
        expect_val(3, 4'b0010, "R7 ch1 flag");
        expect_val(4, 4'b0000, "R7 ch1 one-shot");
        expect_val(5, 0, "R9 no trigger from ch1");
        // Transmit channel match
        arm(0, future(4));
        tick_n(4); @(negedge clk);
        expect_val(3, 4'b0011, "R9 ch0 flag");
        expect_val(5, 1, "R9 single trigger pulse");
        @(negedge clk) irq_clr = 4'b0001;
        @(negedge clk) irq_clr = '0;
        expect_val(3, 4'b0010, "R8 clear ch0 only");
        // Disarm before the match
        arm(2, future(2));
        disarm(2);
        tick_n(4); @(negedge clk);
        expect_val(3, 4'b0010, "R6 disarm blocks match");
        // Target already passed
        arm(3, old_t);
        tick_n(5); @(negedge clk);
        expect_val(4, 4'b1000, "R7 past target silent");
        expect_val(3, 4'b0010, "R7 no flag from past target");
        disarm(3);
        // Match wins over clear
        @(negedge clk) irq_clr = 4'b0010;
        @(negedge clk) irq_clr = '0;
        expect_val(3, 4'b0000, "R8 clear ch1");
        arm(1, future(1));
        tick_n(1);
        irq_clr = 4'b0010;
        @(negedge clk) irq_clr = '0;
        expect_val(3, 4'b0010, "R8 set wins over clear");
        // Write wins over disarm
        @(negedge clk) begin cmp_we = 4'b0100; cmp_disarm = 4'b0100;
                             cmp_wdata = future(5000)[37:0]; end
        @(negedge clk) begin cmp_we = '0; cmp_disarm = '0; end
        expect_val(4, 4'b0100, "R6 write beats disarm");
        disarm(2);
        // Latch holds
        do_latch();
        held = pack(exp_hs, exp_us);
        tick_n(20);
        expect_val(0, held, "R4 latch holds");
        // Wrap of the narrow coarse counter
        while (!(exp_us == 624 && exp_hs % 8 == 0)) tick_n(1);
        do_latch();
        expect_val(6, 64'(624), "R10 narrow coarse wraps to 0");
        expect_val(0, pack(exp_hs, 624), "R10 wide coarse keeps counting");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule